// File: doc/BRIEF.md
# Two-Way Set-Associative Cache with Least-Recently-Used Replacement

This block sits between a processor and a slower backing memory. It holds recently used memory lines in two ways per set. A processor request is split into a tag, a set index and a word offset. Both ways of the addressed set compare their stored tag at the same time, and a match returns the word after a short, fixed delay. On a miss the controller picks a way to replace. It writes that way's line back to memory if it has been modified, reads the wanted line in, and then completes the request as a hit.

Writes follow a write-back policy. A store updates only the cached line and marks it modified, so memory learns of the change when the line is evicted. Replacement uses one use bit per line. Any completed access sets the bit of the line it touched and clears the bit of the other line in that set. When both lines are valid, the line whose bit is clear is the one that goes.

The processor holds `cpu_req` with its command until `cpu_done` pulses. The memory side moves whole lines: `mem_req` is held with a stable block address, direction and write data until `mem_ack` pulses for one cycle. `mem_rdata` is taken during that ack cycle.

Top module: `assoc2_cache`

## Requirements
- R1: The word offset is `addr[OFF_W-1:0]`, the set index is the next `SET_W` bits and the tag is the remaining upper bits, so block j = addr >> OFF_W lives in set j mod SETS. A refill reads block address `{tag, set}` on `mem_addr`, and word k of a line sits at bits `[k*WORD_W +: WORD_W]`.
- R2: Synchronous reset invalidates every line and holds `cpu_done` and `mem_req` low, so the first access to any address after reset is a miss.
- R3: A hit raises `cpu_done` for one cycle on the second rising edge after the request is first sampled, with no memory traffic. On a read, `cpu_rdata` holds the word while `cpu_done` is high.
- R4: On a miss where the set has an invalid way, that way is refilled with a single line read and no write-back. Way 0 is filled before way 1.
- R5: On a miss where both ways are valid, the victim is the way not accessed most recently in that set. Every completed access, whether a hit or the retry after a refill, marks its own line used and clears the use mark of the other line.
- R6: A modified victim is written to memory at its own block address `{stored tag, set}` before the refill read is issued. A clean victim causes no memory write.
- R7: A processor write changes only the cached word and marks the line modified, and it causes no memory write at the time of the store. A write miss first refills the line.
- R8: A read returns the most recently written value for that address, including after the line has been evicted and refilled.
- R9: `mem_req` stays high with stable `mem_addr`, `mem_we` and `mem_wdata` until `mem_ack`, and `cpu_done` is never high for two cycles in a row.
- R10: Accesses to one set never displace lines held in another set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | WORD_W | Write data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | WORD_W | Read data, valid with `cpu_done` |
| mem_req | output | 1 | Memory line transfer request |
| mem_we | output | 1 | 1 = write-back, 0 = refill read |
| mem_addr | output | ADDR_W-OFF_W | Block address of the transfer |
| mem_wdata | output | WORD_W*LINE_WORDS | Line being written back |
| mem_rdata | input | WORD_W*LINE_WORDS | Line returned by memory, taken during `mem_ack` |
| mem_ack | input | 1 | One-cycle completion of a line transfer |

## Verification
A wrong use bit does not show on the access that corrupts it. It shows one conflicting miss later, as a refill of the wrong block, an extra refill on the next access, or a write-back that is missing or comes twice. The bench therefore counts line reads and writes for each request and checks the order of write-back and refill. A lost dirty mark only shows once the evicted block is read again and stale data comes back. For that reason a modified line is evicted and then re-read. Hit latency and handshake stability are checked on every request, because a wrong state transition shows up at once as a changed cycle count or a changing memory address.

// File: rtl/assoc2_pkg.sv
package assoc2_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WBACK,
    ST_FILL,
    ST_REREAD,
    ST_DONE
  } ctl_state_t;

endpackage

// File: rtl/assoc2_line_ram.sv
// One way of line data: simple dual-port RAM with a registered read,
// shaped so a block RAM can be inferred.
module assoc2_line_ram #(
  parameter int SETS   = 8,
  parameter int LINE_W = 32,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [SET_W-1:0]  idx,
  input  logic [LINE_W-1:0] wdata,
  output logic [LINE_W-1:0] rdata
);

  logic [LINE_W-1:0] store [SETS];

  always_ff @(posedge clk) begin
    if (we) store[idx] <= wdata;
    rdata <= store[idx];
  end

endmodule

// File: rtl/assoc2_tag_store.sv
// Tag, valid, modified and use state for both ways, with parallel compare.
module assoc2_tag_store #(
  parameter int SETS  = 8,
  parameter int TAG_W = 5,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [SET_W-1:0]      idx,
  input  logic [TAG_W-1:0]      look_tag,
  output logic [1:0]            hit_vec,
  output logic [1:0]            valid_vec,
  output logic [1:0]            dirty_vec,
  output logic [1:0]            use_vec,
  output logic [1:0][TAG_W-1:0] tag_vec,
  input  logic                  touch_en,
  input  logic                  touch_way,
  input  logic                  touch_write,
  input  logic                  fill_en,
  input  logic                  fill_way,
  input  logic [TAG_W-1:0]      fill_tag
);

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [TAG_W-1:0] tags [SETS];
    logic [SETS-1:0]  vld_q;
    logic [SETS-1:0]  mod_q;
    logic [SETS-1:0]  use_q;
    logic             is_fill;
    logic             is_touch;

    assign is_fill  = fill_en && (fill_way == 1'(w));
    assign is_touch = touch_en && (touch_way == 1'(w));

    always_ff @(posedge clk) begin
      if (is_fill) tags[idx] <= fill_tag;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q <= '0;
        mod_q <= '0;
        use_q <= '0;
      end else begin
        if (is_fill) begin
          vld_q[idx] <= 1'b1;
          mod_q[idx] <= 1'b0;
        end
        if (touch_en) begin
          use_q[idx] <= is_touch;
          if (is_touch && touch_write) mod_q[idx] <= 1'b1;
        end
      end
    end

    assign tag_vec[w]   = tags[idx];
    assign valid_vec[w] = vld_q[idx];
    assign dirty_vec[w] = mod_q[idx];
    assign use_vec[w]   = use_q[idx];
    assign hit_vec[w]   = vld_q[idx] && (tags[idx] == look_tag);
  end

endmodule

// File: rtl/assoc2_victim.sv
// Victim choice: an empty way first (way 0 before way 1), else the way
// whose use bit is clear.
module assoc2_victim (
  input  logic [1:0] valid_vec,
  input  logic [1:0] use_vec,
  output logic       victim_way
);

  always_comb begin
    if (!valid_vec[0])      victim_way = 1'b0;
    else if (!valid_vec[1]) victim_way = 1'b1;
    else                    victim_way = use_vec[0];
  end

endmodule

// File: rtl/assoc2_ctrl.sv
// Request latch, lookup decision and write-back / refill sequencer.
module assoc2_ctrl
  import assoc2_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int WORD_W     = 8,
  parameter int LINE_WORDS = 4,
  parameter int SETS       = 8,
  localparam int OFF_W  = $clog2(LINE_WORDS),
  localparam int SET_W  = $clog2(SETS),
  localparam int TAG_W  = ADDR_W - OFF_W - SET_W,
  localparam int BLK_W  = ADDR_W - OFF_W,
  localparam int LINE_W = WORD_W * LINE_WORDS
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cpu_req,
  input  logic                   cpu_we,
  input  logic [ADDR_W-1:0]      cpu_addr,
  input  logic [WORD_W-1:0]      cpu_wdata,
  output logic                   cpu_done,
  output logic [WORD_W-1:0]      cpu_rdata,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [BLK_W-1:0]       mem_addr,
  output logic [LINE_W-1:0]      mem_wdata,
  input  logic [LINE_W-1:0]      mem_rdata,
  input  logic                   mem_ack,
  output logic [SET_W-1:0]       rd_idx,
  output logic [TAG_W-1:0]       look_tag,
  input  logic [1:0]             hit_vec,
  input  logic [1:0]             valid_vec,
  input  logic [1:0]             dirty_vec,
  input  logic [1:0][TAG_W-1:0]  tag_vec,
  input  logic                   victim_way,
  input  logic [1:0][LINE_W-1:0] line_rd,
  output logic [1:0]             ram_we,
  output logic [LINE_W-1:0]      ram_wdata,
  output logic                   touch_en,
  output logic                   touch_way,
  output logic                   touch_write,
  output logic                   fill_en,
  output logic                   fill_way,
  output logic [TAG_W-1:0]       fill_tag
);

  ctl_state_t          state_q, state_d;
  logic                we_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [WORD_W-1:0]   wdata_q;
  logic                vict_q;

  logic [OFF_W-1:0]    off_q;
  logic [SET_W-1:0]    set_q;
  logic [TAG_W-1:0]    tag_q;
  logic                any_hit;
  logic                hit_way;
  logic [LINE_W-1:0]   hit_line;
  logic [LINE_W-1:0]   merged;
  logic [WORD_W-1:0]   hit_word;

  assign off_q    = addr_q[OFF_W-1:0];
  assign set_q    = addr_q[OFF_W +: SET_W];
  assign tag_q    = addr_q[ADDR_W-1 -: TAG_W];
  assign any_hit  = |hit_vec;
  assign hit_way  = hit_vec[1];
  assign hit_line = line_rd[hit_way];
  assign hit_word = hit_line[off_q*WORD_W +: WORD_W];

  assign rd_idx   = (state_q == ST_IDLE) ? cpu_addr[OFF_W +: SET_W] : set_q;
  assign look_tag = tag_q;

  always_comb begin
    merged = hit_line;
    merged[off_q*WORD_W +: WORD_W] = wdata_q;
  end

  always_comb begin
    state_d     = state_q;
    ram_we      = 2'b00;
    ram_wdata   = merged;
    touch_en    = 1'b0;
    touch_way   = hit_way;
    touch_write = 1'b0;
    fill_en     = 1'b0;
    fill_way    = vict_q;
    fill_tag    = tag_q;
    case (state_q)
      ST_IDLE:   if (cpu_req) state_d = ST_LOOKUP;
      ST_LOOKUP: begin
        if (any_hit) begin
          touch_en    = 1'b1;
          touch_write = we_q;
          if (we_q) ram_we[hit_way] = 1'b1;
          state_d = ST_DONE;
        end else if (valid_vec[victim_way] && dirty_vec[victim_way]) begin
          state_d = ST_WBACK;
        end else begin
          state_d = ST_FILL;
        end
      end
      ST_WBACK:  if (mem_ack) state_d = ST_FILL;
      ST_FILL: begin
        if (mem_ack) begin
          fill_en         = 1'b1;
          ram_we[vict_q]  = 1'b1;
          ram_wdata       = mem_rdata;
          state_d         = ST_REREAD;
        end
      end
      ST_REREAD: state_d = ST_LOOKUP;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      we_q      <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      vict_q    <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && cpu_req) begin
        we_q    <= cpu_we;
        addr_q  <= cpu_addr;
        wdata_q <= cpu_wdata;
      end
      if (state_q == ST_LOOKUP) begin
        if (any_hit) cpu_rdata <= hit_word;
        else         vict_q    <= victim_way;
      end
    end
  end

  assign cpu_done  = (state_q == ST_DONE);
  assign mem_req   = (state_q == ST_WBACK) || (state_q == ST_FILL);
  assign mem_we    = (state_q == ST_WBACK);
  assign mem_addr  = (state_q == ST_WBACK) ? {tag_vec[vict_q], set_q} : {tag_q, set_q};
  assign mem_wdata = (state_q == ST_WBACK) ? line_rd[vict_q] : '0;

endmodule

// File: rtl/assoc2_cache.sv
module assoc2_cache #(
  parameter int ADDR_W     = 10,
  parameter int WORD_W     = 8,
  parameter int LINE_WORDS = 4,
  parameter int SETS       = 8,
  localparam int OFF_W  = $clog2(LINE_WORDS),
  localparam int SET_W  = $clog2(SETS),
  localparam int TAG_W  = ADDR_W - OFF_W - SET_W,
  localparam int BLK_W  = ADDR_W - OFF_W,
  localparam int LINE_W = WORD_W * LINE_WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic              cpu_done,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [BLK_W-1:0]  mem_addr,
  output logic [LINE_W-1:0] mem_wdata,
  input  logic [LINE_W-1:0] mem_rdata,
  input  logic              mem_ack
);

  logic [SET_W-1:0]       rd_idx;
  logic [TAG_W-1:0]       look_tag;
  logic [1:0]             hit_vec;
  logic [1:0]             valid_vec;
  logic [1:0]             dirty_vec;
  logic [1:0]             use_vec;
  logic [1:0][TAG_W-1:0]  tag_vec;
  logic                   victim_way;
  logic [1:0][LINE_W-1:0] line_rd;
  logic [1:0]             ram_we;
  logic [LINE_W-1:0]      ram_wdata;
  logic                   touch_en, touch_way, touch_write;
  logic                   fill_en, fill_way;
  logic [TAG_W-1:0]       fill_tag;

  assoc2_ctrl #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS), .SETS(SETS)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .rd_idx(rd_idx), .look_tag(look_tag),
    .hit_vec(hit_vec), .valid_vec(valid_vec), .dirty_vec(dirty_vec), .tag_vec(tag_vec),
    .victim_way(victim_way), .line_rd(line_rd),
    .ram_we(ram_we), .ram_wdata(ram_wdata),
    .touch_en(touch_en), .touch_way(touch_way), .touch_write(touch_write),
    .fill_en(fill_en), .fill_way(fill_way), .fill_tag(fill_tag)
  );

  assoc2_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst), .idx(rd_idx), .look_tag(look_tag),
    .hit_vec(hit_vec), .valid_vec(valid_vec), .dirty_vec(dirty_vec),
    .use_vec(use_vec), .tag_vec(tag_vec),
    .touch_en(touch_en), .touch_way(touch_way), .touch_write(touch_write),
    .fill_en(fill_en), .fill_way(fill_way), .fill_tag(fill_tag)
  );

  assoc2_victim u_victim (
    .valid_vec(valid_vec), .use_vec(use_vec), .victim_way(victim_way)
  );

  for (genvar w = 0; w < 2; w++) begin : g_data
    assoc2_line_ram #(.SETS(SETS), .LINE_W(LINE_W)) u_ram (
      .clk(clk), .we(ram_we[w]), .idx(rd_idx), .wdata(ram_wdata), .rdata(line_rd[w])
    );
  end

endmodule

// File: rtl/assoc2_cache_chk.sv
module assoc2_cache_chk #(
  parameter int BLK_W  = 8,
  parameter int LINE_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_done,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [BLK_W-1:0]  mem_addr,
  input logic [LINE_W-1:0] mem_wdata,
  input logic [1:0]        hit_vec
);

  assert_reset_quiet_R2: assert property (@(posedge clk)
    rst |=> (!cpu_done && !mem_req));

  assert_hit_no_traffic_R3: assert property (@(posedge clk) disable iff (rst)
    cpu_done |-> !mem_req);

  assert_one_way_match_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  assert_wb_then_fill_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

  assert_mem_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    cpu_done |=> !cpu_done);

endmodule

bind assoc2_cache assoc2_cache_chk #(
  .BLK_W(ADDR_W - $clog2(LINE_WORDS)),
  .LINE_W(WORD_W * LINE_WORDS)
) u_chk (
  .clk(clk), .rst(rst), .cpu_done(cpu_done), .mem_req(mem_req),
  .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .hit_vec(hit_vec)
);

// File: tb/assoc2_cache_test.sv
module assoc2_cache_test;

  localparam int ADDR_W     = 10;
  localparam int WORD_W     = 8;
  localparam int LINE_WORDS = 4;
  localparam int SETS       = 8;
  localparam int BLK_W      = ADDR_W - 2;
  localparam int LINE_W     = WORD_W * LINE_WORDS;
  localparam int NBLK       = 1 << BLK_W;
  localparam int NADDR      = 1 << ADDR_W;
  localparam int NV         = 19;

  // entry: {we, addr[9:0], wdata[7:0], expected line reads, expected line writes}
  // address = tag*32 + set*4 + word
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 10'h024, 8'h00, 1'b1, 1'b0},  // t1 s1: empty set, way 0
    {1'b0, 10'h026, 8'h00, 1'b0, 1'b0},  // hit
    {1'b0, 10'h044, 8'h00, 1'b1, 1'b0},  // t2 s1: way 1
    {1'b1, 10'h027, 8'hC3, 1'b0, 1'b0},  // write hit t1, modified
    {1'b0, 10'h065, 8'h00, 1'b1, 1'b0},  // t3 evicts clean t2
    {1'b0, 10'h027, 8'h00, 1'b0, 1'b0},  // hit t1
    {1'b0, 10'h044, 8'h00, 1'b1, 1'b0},  // t2 evicts clean t3
    {1'b0, 10'h084, 8'h00, 1'b1, 1'b1},  // t4 evicts modified t1
    {1'b0, 10'h027, 8'h00, 1'b1, 1'b0},  // t1 back, evicts t2
    {1'b1, 10'h0A8, 8'h11, 1'b1, 1'b0},  // write miss s2 way 0
    {1'b1, 10'h0C9, 8'h22, 1'b1, 1'b0},  // write miss s2 way 1
    {1'b0, 10'h0A8, 8'h00, 1'b0, 1'b0},  // hit t5
    {1'b0, 10'h0E8, 8'h00, 1'b1, 1'b1},  // t7 evicts modified t6
    {1'b0, 10'h0C9, 8'h00, 1'b1, 1'b1},  // t6 evicts modified t5
    {1'b0, 10'h000, 8'h00, 1'b1, 1'b0},  // lowest address
    {1'b0, 10'h3FF, 8'h00, 1'b1, 1'b0},  // highest address
    {1'b0, 10'h3FF, 8'h00, 1'b0, 1'b0},  // hit
    {1'b0, 10'h027, 8'h00, 1'b0, 1'b0},  // set 1 untouched by others
    {1'b0, 10'h084, 8'h00, 1'b0, 1'b0}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cpu_req = 1'b0;
  logic              cpu_we = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [WORD_W-1:0] cpu_wdata = '0;
  logic              cpu_done;
  logic [WORD_W-1:0] cpu_rdata;
  logic              mem_req;
  logic              mem_we;
  logic [BLK_W-1:0]  mem_addr;
  logic [LINE_W-1:0] mem_wdata;
  logic [LINE_W-1:0] mem_rdata = '0;
  logic              mem_ack = 1'b0;

  always #5 clk = ~clk;

  assoc2_cache #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS), .SETS(SETS)
  ) uut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_done(cpu_done),
    .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack)
  );

  logic [LINE_W-1:0] mem_q [NBLK];
  logic [WORD_W-1:0] gold  [NADDR];
  int checks = 0;
  int fails  = 0;
  int n_rd, n_wr, order_bad, hs_err, pulse_bad, wait_cnt;
  logic [BLK_W-1:0] last_rd_blk, hold_addr;
  logic hold_we;

  function automatic logic [WORD_W-1:0] init_word(int a);
    return WORD_W'((a * 37 + (a >> 8) + 8'h5A) & 8'hFF);
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // backing memory: acks a line transfer on the third sampled cycle
  initial begin
    hs_err = 0;
    wait_cnt = 0;
    forever begin
      @(negedge clk);
      if (rst) begin
        mem_ack = 1'b0;
        wait_cnt = 0;
      end else if (mem_ack) begin
        mem_ack = 1'b0;
        wait_cnt = 0;
      end else if (mem_req) begin
        if (wait_cnt != 0 && (mem_addr != hold_addr || mem_we != hold_we)) hs_err++;
        hold_addr = mem_addr;
        hold_we   = mem_we;
        wait_cnt++;
        if (wait_cnt == 3) begin
          mem_ack = 1'b1;
          if (mem_we) begin
            mem_q[mem_addr] = mem_wdata;
            n_wr++;
            if (n_rd != 0) order_bad++;
          end else begin
            mem_rdata   = mem_q[mem_addr];
            last_rd_blk = mem_addr;
            n_rd++;
          end
        end
      end else begin
        wait_cnt = 0;
      end
    end
  end

  task automatic run_req(input logic we, input logic [ADDR_W-1:0] addr,
                         input logic [WORD_W-1:0] wd,
                         output logic [WORD_W-1:0] rd, output int cyc);
    @(negedge clk);
    n_rd = 0; n_wr = 0; order_bad = 0;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    cyc = 0;
    do begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end while (!cpu_done && cyc < 400);
    rd = cpu_rdata;
    cpu_req = 1'b0;
    @(negedge clk);
    if (cpu_done) pulse_bad++;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R9 watchdog, run still going", 1, 0);
    finish_run();
  end

  initial begin
    logic [WORD_W-1:0] rd;
    int cyc;
    pulse_bad = 0;
    for (int b = 0; b < NBLK; b++)
      for (int k = 0; k < LINE_WORDS; k++)
        mem_q[b][k*WORD_W +: WORD_W] = init_word(b * LINE_WORDS + k);
    for (int a = 0; a < NADDR; a++) gold[a] = init_word(a);

    repeat (3) @(negedge clk);
    chk(!cpu_done && !mem_req, "R2 outputs quiet in reset", {cpu_done, mem_req}, 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic              v_we, e_rd, e_wr;
      logic [ADDR_W-1:0] v_addr;
      logic [WORD_W-1:0] v_wd;
      {v_we, v_addr, v_wd, e_rd, e_wr} = VEC[i];
      run_req(v_we, v_addr, v_wd, rd, cyc);
      chk(n_rd == int'(e_rd), $sformatf("R4/R5 line reads, vector %0d", i), n_rd, e_rd);
      chk(n_wr == int'(e_wr), $sformatf("R6/R7 line writes, vector %0d", i), n_wr, e_wr);
      if (e_rd)
        chk(last_rd_blk == v_addr[ADDR_W-1:2], $sformatf("R1 refill block, vector %0d", i),
            last_rd_blk, v_addr[ADDR_W-1:2]);
      if (e_wr)
        chk(order_bad == 0, $sformatf("R6 write-back before refill, vector %0d", i), order_bad, 0);
      if (!e_rd && !e_wr)
        chk(cyc == 2, $sformatf("R3 hit latency, vector %0d", i), cyc, 2);
      if (i >= 17)
        chk(n_rd == 0, $sformatf("R10 other sets left intact, vector %0d", i), n_rd, 0);
      if (v_we) gold[v_addr] = v_wd;
      else chk(rd == gold[v_addr], $sformatf("R8 read data, vector %0d", i), rd, gold[v_addr]);
    end

    chk(hs_err == 0, "R9 memory request held stable", hs_err, 0);
    chk(pulse_bad == 0, "R9 done single pulse", pulse_bad, 0);

    // reset in service invalidates every line
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(!cpu_done && !mem_req, "R2 outputs quiet in second reset", {cpu_done, mem_req}, 0);
    rst = 1'b0;
    run_req(1'b0, 10'h027, 8'h00, rd, cyc);
    chk(n_rd == 1, "R2 line invalid after reset", n_rd, 1);
    chk(rd == gold[10'h027], "R8 data survives eviction and reset", rd, gold[10'h027]);

    finish_run();
  end

endmodule